// File: doc/BRIEF.md
# Dual-Issue Register Scoreboard

This block sits between a two-wide decode stage and the integer, load/store and floating-point pipes. Each cycle it looks at up to two decoded instructions and grants each slot in the same cycle. An instruction is granted only when all of its sources are ready, its destination can be overwritten safely, and the execution unit it needs is free. When it grants an instruction that writes a register, it loads that register's countdown with a delay set by the operation class. The countdown then falls by one each cycle, and a source counts as ready once its countdown is zero.

The register index space is unified. With the default six-bit index, the 64 entries can hold integer and floating-point registers side by side. The integer divider and the floating-point divider are not pipelined. Each is tracked by its own small state machine with two states. DV_IDLE means the divider is free. The claim transition moves it to DV_BUSY when a divide of its class is granted. DV_BUSY keeps blocking new divides of that class. The release transition returns it to DV_IDLE when the occupancy count runs out.

Issue stays in program order: slot 1 never goes ahead of slot 0. A store-conditional is accepted only in slot 0.

Top module: `dual_issue_scoreboard`

## Requirements
- R1: After reset every register is ready, so a valid instruction with no unit conflict is granted in the same cycle it is presented, whatever sources it reads.
- R2: Class codes and result delays: 0 simple integer 1, 1 multiply 4, 2 integer divide 36, 3 integer load 3, 4 FP load 4, 5 FP arithmetic/move 5, 6 FP divide 30, 7 FP single divide 19, 8 store 1, 9 store-conditional 4, others 1. If a producer is granted in cycle t with delay L, a reader of its destination is held through cycle t+L-1 and granted in cycle t+L.
- R3: Slot 1 is granted only in a cycle where slot 0 is also granted.
- R4: Slot 1 is not granted when an enabled source of slot 1 equals slot 0's enabled destination in the same cycle.
- R5: Slot 1 is not granted when both slots write the same destination register.
- R6: A store-conditional (class 9) is never granted in slot 1. In slot 0 it follows the normal rules.
- R7: The integer divider accepts at most one divide every 33 cycles. At most one divide is granted per cycle, and a divide presented while the divider is busy is held.
- R8: The floating-point divider is shared by classes 6 and 7. It stays occupied for 27 cycles after a class-6 grant and 16 cycles after a class-7 grant. The two slots never both start it in the same cycle.
- R9: An instruction is held while its destination's remaining count is greater than or equal to its own delay, so results always land in program order.
- R10: An invalid slot is never granted and records nothing. A source whose enable bit is clear is not checked.
- R11: An instruction with its destination enable clear changes no register's countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_class | input | 4 | Slot 0 operation class |
| s0_dst_en | input | 1 | Slot 0 writes a register |
| s0_dst | input | REG_W | Slot 0 destination index |
| s0_src_en | input | NSRC | Slot 0 per-source enables |
| s0_srcs | input | NSRC*REG_W | Slot 0 source indices, source k at bits k*REG_W |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_class | input | 4 | Slot 1 operation class |
| s1_dst_en | input | 1 | Slot 1 writes a register |
| s1_dst | input | REG_W | Slot 1 destination index |
| s1_src_en | input | NSRC | Slot 1 per-source enables |
| s1_srcs | input | NSRC*REG_W | Slot 1 source indices |
| s0_grant | output | 1 | Slot 0 issues this cycle |
| s1_grant | output | 1 | Slot 1 issues this cycle |

## Verification
The bound checker watches the pairing rules on every cycle: slot 1 never issues alone, never issues a store-conditional, never reads or rewrites slot 0's destination, invalid slots stay ungranted, and the spacing between integer divides. The exact delay for each class, the write-after-write hold, the occupancy of the shared floating-point divider, and the rule that disabled sources and disabled destinations have no effect all depend on counts carried across many cycles. Only the bench scenarios show these, by stepping the cycle in which a dependent instruction is held and then granted.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        OC_ALU   = 4'd0,
        OC_MUL   = 4'd1,
        OC_IDIV  = 4'd2,
        OC_LOAD  = 4'd3,
        OC_FLOAD = 4'd4,
        OC_FPU   = 4'd5,
        OC_FDIV  = 4'd6,
        OC_FDIVS = 4'd7,
        OC_STORE = 4'd8,
        OC_STCX  = 4'd9
    } op_class_e;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_BUSY = 1'b1
    } dv_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sb_div_fsm.sv
module sb_div_fsm #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] occ,
    output logic             busy
);
    import sb_pkg::*;

    dv_state_e        st_q, st_d;
    logic [CNT_W-1:0] left_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DV_IDLE;
        else        st_q <= st_d;
    end

    // transitions: claim (idle->busy), release (busy->idle)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_IDLE: if (start) st_d = DV_BUSY;
            DV_BUSY: if (left_q <= CNT_W'(1)) st_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (st_q == DV_IDLE && start)
            left_q <= occ - CNT_W'(1);
        else if (st_q == DV_BUSY && left_q != '0)
            left_q <= left_q - CNT_W'(1);
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        unique case (st_q)
            DV_IDLE: busy = 1'b0;
            DV_BUSY: busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/sb_reg_timers.sv
module sb_reg_timers #(
    parameter int REG_W = 6,
    parameter int CNT_W = 6,
    parameter int NRD   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 wr_en,
    input  logic [1:0][REG_W-1:0]      wr_idx,
    input  logic [1:0][CNT_W-1:0]      wr_val,
    input  logic [NRD-1:0][REG_W-1:0]  rd_idx,
    output logic [NRD-1:0][CNT_W-1:0]  rd_cnt
);
    localparam int NREG = 1 << REG_W;

    logic [CNT_W-1:0] cnt_q [NREG];

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            logic hit0, hit1;
            assign hit0 = wr_en[0] && (wr_idx[0] == REG_W'(r));
            assign hit1 = wr_en[1] && (wr_idx[1] == REG_W'(r));
            always_ff @(posedge clk) begin
                if (!rst_n)              cnt_q[r] <= '0;
                else if (hit1)           cnt_q[r] <= wr_val[1];
                else if (hit0)           cnt_q[r] <= wr_val[0];
                else if (cnt_q[r] != '0) cnt_q[r] <= cnt_q[r] - CNT_W'(1);
            end
        end
        for (genvar k = 0; k < NRD; k++) begin : g_rd
            assign rd_cnt[k] = cnt_q[rd_idx[k]];
        end
    endgenerate
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
    parameter int REG_W     = 6,
    parameter int NSRC      = 3,
    parameter int CNT_W     = 6,
    parameter int LAT_ALU   = 1,
    parameter int LAT_MUL   = 4,
    parameter int LAT_IDIV  = 36,
    parameter int LAT_LOAD  = 3,
    parameter int LAT_FLOAD = 4,
    parameter int LAT_FPU   = 5,
    parameter int LAT_FDIV  = 30,
    parameter int LAT_FDIVS = 19,
    parameter int LAT_STORE = 1,
    parameter int LAT_STCX  = 4,
    parameter int OCC_FDIV  = 27,
    parameter int OCC_FDIVS = 16
) (
    input  logic [1:0]                                 valid,
    input  logic [1:0][sb_pkg::CLS_W-1:0]              cls,
    input  logic [1:0]                                 dst_en,
    input  logic [1:0][REG_W-1:0]                      dst,
    input  logic [1:0][NSRC-1:0]                       src_en,
    input  logic [1:0][NSRC-1:0][REG_W-1:0]            src,
    input  logic [1:0][NSRC-1:0][CNT_W-1:0]            src_cnt,
    input  logic [1:0][CNT_W-1:0]                      dst_cnt,
    input  logic                                       idiv_busy,
    input  logic                                       fdiv_busy,
    output logic [1:0]                                 grant,
    output logic [1:0]                                 wr_en,
    output logic [1:0][CNT_W-1:0]                      wr_val,
    output logic                                       idiv_start,
    output logic                                       fdiv_start,
    output logic [CNT_W-1:0]                           fdiv_occ
);
    import sb_pkg::*;

    function automatic logic [CNT_W-1:0] lat_of(input logic [CLS_W-1:0] c);
        case (c)
            OC_MUL:   return CNT_W'(LAT_MUL);
            OC_IDIV:  return CNT_W'(LAT_IDIV);
            OC_LOAD:  return CNT_W'(LAT_LOAD);
            OC_FLOAD: return CNT_W'(LAT_FLOAD);
            OC_FPU:   return CNT_W'(LAT_FPU);
            OC_FDIV:  return CNT_W'(LAT_FDIV);
            OC_FDIVS: return CNT_W'(LAT_FDIVS);
            OC_STORE: return CNT_W'(LAT_STORE);
            OC_STCX:  return CNT_W'(LAT_STCX);
            default:  return CNT_W'(LAT_ALU);
        endcase
    endfunction

    logic [1:0]            ok, is_id, is_fd;
    logic [1:0][CNT_W-1:0] lat;

    generate
        for (genvar i = 0; i < 2; i++) begin : g_slot
            logic raw, waw, unit_blk;
            always_comb begin
                raw = 1'b0;
                for (int j = 0; j < NSRC; j++)
                    raw = raw | (src_en[i][j] && (src_cnt[i][j] != '0));
            end
            assign lat[i]   = lat_of(cls[i]);
            assign is_id[i] = (cls[i] == OC_IDIV);
            assign is_fd[i] = (cls[i] == OC_FDIV) || (cls[i] == OC_FDIVS);
            assign waw      = dst_en[i] && (dst_cnt[i] >= lat[i]);
            assign unit_blk = (is_id[i] && idiv_busy) || (is_fd[i] && fdiv_busy);
            assign ok[i]    = valid[i] && !raw && !waw && !unit_blk;
            assign wr_en[i] = grant[i] && dst_en[i];
            assign wr_val[i] = lat[i] - CNT_W'(1);
        end
    endgenerate

    logic pair_raw, pair_waw, pair_unit;

    always_comb begin
        pair_raw = 1'b0;
        for (int j = 0; j < NSRC; j++)
            pair_raw = pair_raw | (dst_en[0] && src_en[1][j] && (src[1][j] == dst[0]));
    end

    assign pair_waw  = dst_en[0] && dst_en[1] && (dst[0] == dst[1]);
    assign pair_unit = (is_id[0] && is_id[1]) || (is_fd[0] && is_fd[1]);

    assign grant[0] = ok[0];
    assign grant[1] = ok[0] && ok[1] && (cls[1] != OC_STCX)
                      && !pair_raw && !pair_waw && !pair_unit;

    assign idiv_start = (grant[0] && is_id[0]) || (grant[1] && is_id[1]);
    assign fdiv_start = (grant[0] && is_fd[0]) || (grant[1] && is_fd[1]);

    logic [CLS_W-1:0] fd_cls;
    assign fd_cls   = (grant[0] && is_fd[0]) ? cls[0] : cls[1];
    assign fdiv_occ = (fd_cls == OC_FDIVS) ? CNT_W'(OCC_FDIVS) : CNT_W'(OCC_FDIV);
endmodule

// File: rtl/dual_issue_scoreboard.sv
module dual_issue_scoreboard #(
    parameter int REG_W     = 6,
    parameter int NSRC      = 3,
    parameter int LAT_ALU   = 1,
    parameter int LAT_MUL   = 4,
    parameter int LAT_IDIV  = 36,
    parameter int LAT_LOAD  = 3,
    parameter int LAT_FLOAD = 4,
    parameter int LAT_FPU   = 5,
    parameter int LAT_FDIV  = 30,
    parameter int LAT_FDIVS = 19,
    parameter int LAT_STORE = 1,
    parameter int LAT_STCX  = 4,
    parameter int OCC_IDIV  = 33,
    parameter int OCC_FDIV  = 27,
    parameter int OCC_FDIVS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s0_valid,
    input  logic [3:0]            s0_class,
    input  logic                  s0_dst_en,
    input  logic [REG_W-1:0]      s0_dst,
    input  logic [NSRC-1:0]       s0_src_en,
    input  logic [NSRC*REG_W-1:0] s0_srcs,
    input  logic                  s1_valid,
    input  logic [3:0]            s1_class,
    input  logic                  s1_dst_en,
    input  logic [REG_W-1:0]      s1_dst,
    input  logic [NSRC-1:0]       s1_src_en,
    input  logic [NSRC*REG_W-1:0] s1_srcs,
    output logic                  s0_grant,
    output logic                  s1_grant
);
    import sb_pkg::*;

    localparam int MAX_LAT = imax(imax(imax(LAT_ALU, LAT_MUL), imax(LAT_IDIV, LAT_LOAD)),
                             imax(imax(imax(LAT_FLOAD, LAT_FPU), imax(LAT_FDIV, LAT_FDIVS)),
                                  imax(imax(LAT_STORE, LAT_STCX), imax(OCC_IDIV, imax(OCC_FDIV, OCC_FDIVS)))));
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam int NRD     = 2 * NSRC + 2;

    logic [1:0]                      valid_v, dst_en_v, grant_v, wr_en_v;
    logic [1:0][CLS_W-1:0]           cls_v;
    logic [1:0][REG_W-1:0]           dst_v;
    logic [1:0][NSRC-1:0]            src_en_v;
    logic [1:0][NSRC-1:0][REG_W-1:0] src_v;
    logic [1:0][NSRC-1:0][CNT_W-1:0] src_cnt_v;
    logic [1:0][CNT_W-1:0]           dst_cnt_v, wr_val_v;
    logic [NRD-1:0][REG_W-1:0]       rd_idx;
    logic [NRD-1:0][CNT_W-1:0]       rd_cnt;
    logic                            idiv_start, fdiv_start, idiv_busy, fdiv_busy;
    logic [CNT_W-1:0]                fdiv_occ;

    assign valid_v  = {s1_valid, s0_valid};
    assign dst_en_v = {s1_dst_en, s0_dst_en};
    assign cls_v[0] = s0_class;
    assign cls_v[1] = s1_class;
    assign dst_v[0] = s0_dst;
    assign dst_v[1] = s1_dst;
    assign src_en_v[0] = s0_src_en;
    assign src_en_v[1] = s1_src_en;
    assign src_v[0] = s0_srcs;
    assign src_v[1] = s1_srcs;

    generate
        for (genvar i = 0; i < 2; i++) begin : g_map
            for (genvar j = 0; j < NSRC; j++) begin : g_src
                assign rd_idx[i*NSRC+j]  = src_v[i][j];
                assign src_cnt_v[i][j]   = rd_cnt[i*NSRC+j];
            end
            assign rd_idx[2*NSRC+i] = dst_v[i];
            assign dst_cnt_v[i]     = rd_cnt[2*NSRC+i];
        end
    endgenerate

    sb_reg_timers #(.REG_W(REG_W), .CNT_W(CNT_W), .NRD(NRD)) u_timers (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_v), .wr_idx(dst_v), .wr_val(wr_val_v),
        .rd_idx(rd_idx), .rd_cnt(rd_cnt)
    );

    sb_issue_ctl #(
        .REG_W(REG_W), .NSRC(NSRC), .CNT_W(CNT_W),
        .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL), .LAT_IDIV(LAT_IDIV), .LAT_LOAD(LAT_LOAD),
        .LAT_FLOAD(LAT_FLOAD), .LAT_FPU(LAT_FPU), .LAT_FDIV(LAT_FDIV), .LAT_FDIVS(LAT_FDIVS),
        .LAT_STORE(LAT_STORE), .LAT_STCX(LAT_STCX), .OCC_FDIV(OCC_FDIV), .OCC_FDIVS(OCC_FDIVS)
    ) u_ctl (
        .valid(valid_v), .cls(cls_v), .dst_en(dst_en_v), .dst(dst_v),
        .src_en(src_en_v), .src(src_v), .src_cnt(src_cnt_v), .dst_cnt(dst_cnt_v),
        .idiv_busy(idiv_busy), .fdiv_busy(fdiv_busy),
        .grant(grant_v), .wr_en(wr_en_v), .wr_val(wr_val_v),
        .idiv_start(idiv_start), .fdiv_start(fdiv_start), .fdiv_occ(fdiv_occ)
    );

    sb_div_fsm #(.CNT_W(CNT_W)) u_idiv (
        .clk(clk), .rst_n(rst_n), .start(idiv_start),
        .occ(CNT_W'(OCC_IDIV)), .busy(idiv_busy)
    );

    sb_div_fsm #(.CNT_W(CNT_W)) u_fdiv (
        .clk(clk), .rst_n(rst_n), .start(fdiv_start),
        .occ(fdiv_occ), .busy(fdiv_busy)
    );

    assign s0_grant = grant_v[0];
    assign s1_grant = grant_v[1];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int REG_W    = 6,
    parameter int NSRC     = 3,
    parameter int OCC_IDIV = 33
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  s0_valid,
    input logic [3:0]            s0_class,
    input logic                  s0_dst_en,
    input logic [REG_W-1:0]      s0_dst,
    input logic                  s1_valid,
    input logic [3:0]            s1_class,
    input logic                  s1_dst_en,
    input logic [REG_W-1:0]      s1_dst,
    input logic [NSRC-1:0]       s1_src_en,
    input logic [NSRC*REG_W-1:0] s1_srcs,
    input logic                  s0_grant,
    input logic                  s1_grant
);
    import sb_pkg::*;

    localparam int SW = $clog2(OCC_IDIV + 1) + 1;

    logic          idiv_go, seen_q, reads_s0;
    logic [SW-1:0] since_q;

    assign idiv_go = (s0_grant && s0_class == OC_IDIV) || (s1_grant && s1_class == OC_IDIV);

    always_comb begin
        reads_s0 = 1'b0;
        for (int j = 0; j < NSRC; j++)
            reads_s0 = reads_s0 | (s1_src_en[j] && s1_srcs[j*REG_W +: REG_W] == s0_dst);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (idiv_go) begin
            seen_q  <= 1'b1;
            since_q <= SW'(1);
        end else if (since_q < SW'(OCC_IDIV)) begin
            since_q <= since_q + SW'(1);
        end
    end

    assert_slot1_follows_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_grant |-> s0_grant);
    assert_no_pair_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_grant && s0_dst_en) |-> !reads_s0);
    assert_no_pair_waw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_grant && s0_dst_en && s1_dst_en) |-> (s0_dst != s1_dst));
    assert_no_stcx_slot1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_grant |-> (s1_class != OC_STCX));
    assert_one_idiv_per_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s0_grant && s1_grant && s0_class == OC_IDIV && s1_class == OC_IDIV));
    assert_idiv_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idiv_go |-> (!seen_q || since_q >= SW'(OCC_IDIV)));
    assert_invalid_s0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_valid |-> !s0_grant);
    assert_invalid_s1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |-> !s1_grant);
endmodule

bind dual_issue_scoreboard sb_checker #(.REG_W(REG_W), .NSRC(NSRC), .OCC_IDIV(OCC_IDIV)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_class(s0_class), .s0_dst_en(s0_dst_en), .s0_dst(s0_dst),
    .s1_valid(s1_valid), .s1_class(s1_class), .s1_dst_en(s1_dst_en), .s1_dst(s1_dst),
    .s1_src_en(s1_src_en), .s1_srcs(s1_srcs),
    .s0_grant(s0_grant), .s1_grant(s1_grant)
);

// File: tb/tb_dual_issue_scoreboard.sv
module tb_dual_issue_scoreboard;
    localparam int REG_W = 6;
    localparam int NSRC  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_valid = 0, s1_valid = 0, s0_dst_en = 0, s1_dst_en = 0;
    logic [3:0] s0_class = 0, s1_class = 0;
    logic [REG_W-1:0] s0_dst = 0, s1_dst = 0;
    logic [NSRC-1:0] s0_src_en = 0, s1_src_en = 0;
    logic [NSRC*REG_W-1:0] s0_srcs = 0, s1_srcs = 0;
    logic s0_grant, s1_grant;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct { bit e0; bit e1; string tag; } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    dual_issue_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_class(s0_class), .s0_dst_en(s0_dst_en), .s0_dst(s0_dst),
        .s0_src_en(s0_src_en), .s0_srcs(s0_srcs),
        .s1_valid(s1_valid), .s1_class(s1_class), .s1_dst_en(s1_dst_en), .s1_dst(s1_dst),
        .s1_src_en(s1_src_en), .s1_srcs(s1_srcs),
        .s0_grant(s0_grant), .s1_grant(s1_grant)
    );

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (expq.size() != 0) begin
            exp_t it;
            it = expq.pop_front();
            n_tests++;
            if (s0_grant !== it.e0 || s1_grant !== it.e1) begin
                n_fail++;
                $display("FAIL %s: grants got %b%b expected %b%b", it.tag, s0_grant, s1_grant, it.e0, it.e1);
            end
        end
    end

    task automatic put0(bit v, int cls, bit de, int d, bit [2:0] se, int a, int b, int c);
        s0_valid = v; s0_class = 4'(cls); s0_dst_en = de; s0_dst = REG_W'(d);
        s0_src_en = se; s0_srcs = {REG_W'(c), REG_W'(b), REG_W'(a)};
    endtask

    task automatic put1(bit v, int cls, bit de, int d, bit [2:0] se, int a, int b, int c);
        s1_valid = v; s1_class = 4'(cls); s1_dst_en = de; s1_dst = REG_W'(d);
        s1_src_en = se; s1_srcs = {REG_W'(c), REG_W'(b), REG_W'(a)};
    endtask

    task automatic idle();
        put0(0, 0, 0, 0, 3'b000, 0, 0, 0);
        put1(0, 0, 0, 0, 3'b000, 0, 0, 0);
    endtask

    // driver: queue the expectation for the current inputs, advance one cycle
    task automatic step(bit e0, bit e1, string tag);
        exp_t it;
        it.e0 = e0; it.e1 = e1; it.tag = tag;
        expq.push_back(it);
        @(posedge clk);
        #1;
    endtask

    task automatic drain(int n);
        idle();
        for (int k = 0; k < n; k++) step(0, 0, "R10 idle");
    endtask

    task automatic check_lat(int cls, int lat, int d, string tag);
        idle();
        put0(1, cls, 1, d, 3'b000, 0, 0, 0);
        step(1, 0, tag);
        put0(1, 0, 0, 0, 3'b001, d, 0, 0);
        for (int k = 1; k < lat; k++) step(0, 0, tag);
        step(1, 0, tag);
        idle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        step(0, 0, "R10 idle after reset");
        // R1: everything ready after reset
        put0(1, 0, 1, 5, 3'b111, 1, 2, 3);
        put1(1, 0, 1, 6, 3'b111, 60, 61, 62);
        step(1, 1, "R1 fresh state");

        // R2: per-class delays
        check_lat(0, 1, 7, "R2 simple");
        check_lat(1, 4, 8, "R2 multiply");
        check_lat(3, 3, 9, "R2 int load");
        check_lat(4, 4, 33, "R2 fp load");
        check_lat(5, 5, 34, "R2 fp arith");
        check_lat(9, 4, 12, "R2 store-cond");
        check_lat(7, 19, 35, "R2 fp sdiv");
        check_lat(6, 30, 36, "R2 fp div");
        check_lat(2, 36, 13, "R2 int div");

        // R3: slot 1 waits for slot 0
        idle();
        put0(1, 1, 1, 14, 3'b000, 0, 0, 0);
        step(1, 0, "R3 producer");
        put0(1, 0, 0, 0, 3'b001, 14, 0, 0);
        put1(1, 0, 1, 15, 3'b000, 0, 0, 0);
        for (int k = 1; k < 4; k++) step(0, 0, "R3 slot0 stalled");
        step(1, 1, "R3 pair released");
        put0(0, 0, 0, 0, 3'b000, 0, 0, 0);
        step(0, 0, "R3 slot0 empty");

        // R4: same-cycle read of slot 0 result
        put0(1, 0, 1, 16, 3'b000, 0, 0, 0);
        put1(1, 0, 1, 17, 3'b010, 0, 16, 0);
        step(1, 0, "R4 pair raw");
        put0(1, 0, 1, 17, 3'b010, 0, 16, 0);
        put1(0, 0, 0, 0, 3'b000, 0, 0, 0);
        step(1, 0, "R4 next cycle");

        // R5: same destination in both slots
        put0(1, 0, 1, 18, 3'b000, 0, 0, 0);
        put1(1, 0, 1, 18, 3'b000, 0, 0, 0);
        step(1, 0, "R5 same dst");
        put1(1, 0, 1, 19, 3'b000, 0, 0, 0);
        step(1, 1, "R5 distinct dst");

        // R6: store-conditional slot restriction
        put0(1, 0, 1, 20, 3'b000, 0, 0, 0);
        put1(1, 9, 1, 21, 3'b000, 0, 0, 0);
        step(1, 0, "R6 stcx in slot1");
        put0(1, 9, 1, 21, 3'b000, 0, 0, 0);
        put1(0, 0, 0, 0, 3'b000, 0, 0, 0);
        step(1, 0, "R6 stcx in slot0");
        drain(4);

        // R7: integer divider occupancy
        put0(1, 2, 1, 22, 3'b000, 0, 0, 0);
        put1(1, 2, 1, 23, 3'b000, 0, 0, 0);
        step(1, 0, "R7 two divides");
        put0(1, 2, 1, 23, 3'b000, 0, 0, 0);
        put1(0, 0, 0, 0, 3'b000, 0, 0, 0);
        for (int k = 1; k < 33; k++) step(0, 0, "R7 divider busy");
        step(1, 0, "R7 divider free");
        put0(1, 0, 0, 0, 3'b001, 22, 0, 0);
        step(0, 0, "R2 div result k34");
        step(0, 0, "R2 div result k35");
        step(1, 0, "R2 div result k36");
        drain(40);

        // R8: shared fp divider
        put0(1, 6, 1, 37, 3'b000, 0, 0, 0);
        step(1, 0, "R8 fdiv start");
        put0(1, 7, 1, 38, 3'b000, 0, 0, 0);
        for (int k = 1; k < 27; k++) step(0, 0, "R8 fdiv busy");
        step(1, 0, "R8 fdivs after fdiv");
        put0(1, 6, 1, 39, 3'b000, 0, 0, 0);
        for (int k = 1; k < 16; k++) step(0, 0, "R8 fdivs busy");
        step(1, 0, "R8 fdiv after fdivs");
        drain(31);
        put0(1, 7, 1, 40, 3'b000, 0, 0, 0);
        put1(1, 6, 1, 41, 3'b000, 0, 0, 0);
        step(1, 0, "R8 pair shares divider");
        drain(32);

        // R9: write-after-write ordering
        put0(1, 5, 1, 42, 3'b000, 0, 0, 0);
        step(1, 0, "R9 fpu producer");
        put0(1, 1, 1, 42, 3'b000, 0, 0, 0);
        step(0, 0, "R9 mul held");
        step(1, 0, "R9 mul released");
        put0(1, 0, 0, 0, 3'b001, 42, 0, 0);
        for (int k = 1; k < 4; k++) step(0, 0, "R9 reader of rewrite");
        step(1, 0, "R9 reader of rewrite");
        put0(1, 5, 1, 43, 3'b000, 0, 0, 0);
        step(1, 0, "R9 fpu producer");
        put0(1, 0, 1, 43, 3'b000, 0, 0, 0);
        for (int k = 1; k < 5; k++) step(0, 0, "R9 simple held");
        step(1, 0, "R9 simple released");

        // R10: disabled sources, invalid slot
        put0(1, 5, 1, 44, 3'b000, 0, 0, 0);
        step(1, 0, "R10 producer");
        put0(1, 0, 1, 45, 3'b000, 44, 44, 44);
        step(1, 0, "R10 disabled sources");
        put0(0, 6, 1, 46, 3'b000, 0, 0, 0);
        step(0, 0, "R10 invalid slot");
        put0(1, 6, 1, 47, 3'b001, 46, 0, 0);
        step(1, 0, "R10 invalid left nothing");
        drain(30);

        // R11: no destination enable
        put0(1, 1, 0, 48, 3'b000, 0, 0, 0);
        step(1, 0, "R11 no dst");
        put0(1, 0, 0, 0, 3'b001, 48, 0, 0);
        step(1, 0, "R11 reader free");

        idle();
        @(negedge clk);
        #1;
        done = 1;
        summary();
        $finish;
    end
endmodule